// File: doc/BRIEF.md
# Sizable ROM Window Memory Mapper

This block decodes the top byte of a 64KB processor address into three active-low chip selects: one for the RAM in the lower 32KB, one for the RAM in the upper 32KB, and one for a 32KB ROM. A ROM window sits at the very top of the address space. A 3-bit size code sets its size, from nothing at all up to 16KB, in power-of-two steps starting at 256 bytes. Reads that land in the window enable the ROM. Writes that land in the window go to the upper RAM that lies beneath it, so software can copy ROM contents into shadow RAM in place.

The largest window is built from two 8KB banks. The lower bank covers 0xC000–0xDFFF and the upper bank covers 0xE000–0xFFFF. Each bank has its own 2-bit page input, which picks one of four 8KB pages of the ROM. The block drives the chosen page onto ROM address bits 14:13, and the processor supplies bits 12:0 directly. Any window smaller than 16KB lies wholly inside the upper bank, so only that bank's page is ever visible through it.

The block is purely combinational. Its internal stages are a size-keyed window comparator, a region classifier that drives the selects, and a page multiplexer.

Top module: `rom_window_mapper`

## Requirements
- R1: While `mreq_n` is 1, all three selects (`lo_ram_sel_n`, `hi_ram_sel_n`, `rom_sel_n`) are 1, whatever the address, size code and write inputs are.
- R2: An active request (`mreq_n`=0) with address bit 15 = 0 drives `lo_ram_sel_n`=0 and both other selects to 1.
- R3: An active request with address bit 15 = 1 that falls outside the ROM window drives `hi_ram_sel_n`=0 and both other selects to 1.
- R4: The window's lowest address is 0x10000 minus (256 << (code-1)) for size codes 1 to 7. That gives 0xFF00 for code 1, 0xFE00 for 2, 0xFC00 for 3, 0xF800 for 4, 0xF000 for 5, 0xE000 for 6 and 0xC000 for 7. Code 0 has no window, so 0xFF00–0xFFFF maps to the upper RAM.
- R5: A read (`wr_n`=1) inside the window drives `rom_sel_n`=0 and both RAM selects to 1.
- R6: A write (`wr_n`=0) inside the window leaves `rom_sel_n`=1 and drives `hi_ram_sel_n`=0.
- R7: `rom_page` equals `page_lo_bank` when address bit 13 is 0 and `page_hi_bank` when it is 1. This holds whether or not the ROM is selected.
- R8: For size codes 1 to 6, every ROM-selecting access drives `rom_page` with `page_hi_bank`.
- R9: At most one select is 0 at any time, and exactly one is 0 whenever `mreq_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mreq_n | input | 1 | Memory request strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cpu_addr_hi | input | 8 | Processor address bits 15:8 |
| win_size | input | 3 | ROM window size code, 0 = no window |
| page_lo_bank | input | 2 | ROM page for the 0xC000–0xDFFF bank |
| page_hi_bank | input | 2 | ROM page for the 0xE000–0xFFFF bank |
| lo_ram_sel_n | output | 1 | Lower RAM select, active low |
| hi_ram_sel_n | output | 1 | Upper RAM select, active low |
| rom_sel_n | output | 1 | ROM select, active low |
| rom_page | output | 2 | ROM address bits 14:13 |

## Verification
The block holds no state, so a wrong internal decision shows at the ports in the same evaluation as the input that caused it. A misclassified region shows up as the wrong select or as two selects at once. A wrong window comparator moves the first ROM-selecting address for a size code up or down by a power of two. A swapped page multiplexer shows up as the wrong page at either half of the top 16KB. Sweeping every upper-address byte against every size code, both strobes and several page pairs exposes each of these on the first input vector that exercises it.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    // Which device an access resolves to
    typedef enum logic [1:0] {
        REG_IDLE   = 2'd0,
        REG_LO_RAM = 2'd1,
        REG_HI_RAM = 2'd2,
        REG_ROM    = 2'd3
    } region_e;

endpackage

// File: rtl/window_match.sv
module window_match #(
    parameter int HI_W   = 8,
    parameter int SIZE_W = 3
) (
    input  logic [HI_W-1:0]   addr_hi,
    input  logic [SIZE_W-1:0] size_code,
    output logic              in_window
);
    localparam int NUM_SIZES = 2 ** SIZE_W;

    logic [NUM_SIZES-1:0] hit;

    assign hit[0] = 1'b0;

    // Code s opens the top 256 << (s-1) bytes: address bits above s-2 all ones
    generate
        for (genvar s = 1; s < NUM_SIZES; s++) begin : g_size
            assign hit[s] = &addr_hi[HI_W-1:s-1];
        end
    endgenerate

    assign in_window = hit[size_code];

    // A larger window always contains every smaller one
    generate
        for (genvar s = 1; s < NUM_SIZES - 1; s++) begin : g_nest
            always_comb begin
                if (!$isunknown(addr_hi))
                    AST_WINDOW_NESTED: assert (!hit[s] || hit[s+1])
                        else $error("window for code %0d not nested", s); // R4
            end
        end
    endgenerate

endmodule

// File: rtl/region_select.sv
module region_select
    import mapper_pkg::*;
(
    input  logic mreq_n,
    input  logic wr_n,
    input  logic upper_half,
    input  logic in_window,
    output logic lo_ram_sel_n,
    output logic hi_ram_sel_n,
    output logic rom_sel_n
);
    region_e region;

    // Classification process
    always_comb begin
        if (mreq_n)
            region = REG_IDLE;
        else if (!upper_half)
            region = REG_LO_RAM;
        else if (in_window && wr_n)
            region = REG_ROM;
        else
            region = REG_HI_RAM;   // outside the window, or a write-through
    end

    // Output process
    always_comb begin
        lo_ram_sel_n = 1'b1;
        hi_ram_sel_n = 1'b1;
        rom_sel_n    = 1'b1;
        unique case (region)
            REG_IDLE:   ;
            REG_LO_RAM: lo_ram_sel_n = 1'b0;
            REG_HI_RAM: hi_ram_sel_n = 1'b0;
            REG_ROM:    rom_sel_n    = 1'b0;
            default:    ;
        endcase
    end

    always_comb begin
        if (!$isunknown({mreq_n, wr_n, upper_half, in_window})) begin
            AST_IDLE_QUIET: assert (!mreq_n || (lo_ram_sel_n && hi_ram_sel_n && rom_sel_n))
                else $error("select active without request"); // R1
            AST_WRITE_SHADOW: assert (!(!mreq_n && !wr_n && upper_half && in_window) || !hi_ram_sel_n)
                else $error("window write missed upper RAM"); // R6
        end
    end

endmodule

// File: rtl/page_mux.sv
module page_mux #(
    parameter int PAGE_W = 2
) (
    input  logic              bank_bit,
    input  logic [PAGE_W-1:0] page_lo_bank,
    input  logic [PAGE_W-1:0] page_hi_bank,
    output logic [PAGE_W-1:0] rom_page
);
    always_comb begin
        rom_page = bank_bit ? page_hi_bank : page_lo_bank;
    end

endmodule

// File: rtl/rom_window_mapper.sv
module rom_window_mapper #(
    parameter int ADDR_W    = 16,
    parameter int DEC_LSB   = 8,
    parameter int SIZE_W    = 3,
    parameter int BANK_BITS = 13,
    parameter int PAGE_W    = 2
) (
    input  logic                      mreq_n,
    input  logic                      wr_n,
    input  logic [ADDR_W-1:DEC_LSB]   cpu_addr_hi,
    input  logic [SIZE_W-1:0]         win_size,
    input  logic [PAGE_W-1:0]         page_lo_bank,
    input  logic [PAGE_W-1:0]         page_hi_bank,
    output logic                      lo_ram_sel_n,
    output logic                      hi_ram_sel_n,
    output logic                      rom_sel_n,
    output logic [PAGE_W-1:0]         rom_page
);
    localparam int HI_W     = ADDR_W - DEC_LSB;
    localparam int MAX_CODE = 2 ** SIZE_W - 1;

    logic [HI_W-1:0] addr_field;
    logic            in_window;

    assign addr_field = cpu_addr_hi;

    window_match #(.HI_W(HI_W), .SIZE_W(SIZE_W)) u_match (
        .addr_hi   (addr_field),
        .size_code (win_size),
        .in_window (in_window)
    );

    region_select u_region (
        .mreq_n       (mreq_n),
        .wr_n         (wr_n),
        .upper_half   (cpu_addr_hi[ADDR_W-1]),
        .in_window    (in_window),
        .lo_ram_sel_n (lo_ram_sel_n),
        .hi_ram_sel_n (hi_ram_sel_n),
        .rom_sel_n    (rom_sel_n)
    );

    page_mux #(.PAGE_W(PAGE_W)) u_page (
        .bank_bit     (cpu_addr_hi[BANK_BITS]),
        .page_lo_bank (page_lo_bank),
        .page_hi_bank (page_hi_bank),
        .rom_page     (rom_page)
    );

    always_comb begin
        if (!$isunknown({mreq_n, wr_n, cpu_addr_hi, win_size, page_lo_bank, page_hi_bank})) begin
            AST_ONE_SELECT: assert ($countones({~lo_ram_sel_n, ~hi_ram_sel_n, ~rom_sel_n}) == (mreq_n ? 0 : 1))
                else $error("select count wrong"); // R9
            AST_LOW_HALF: assert (mreq_n || cpu_addr_hi[ADDR_W-1] || !lo_ram_sel_n)
                else $error("lower half not on lower RAM"); // R2
            AST_ROM_UPPER: assert (rom_sel_n || cpu_addr_hi[ADDR_W-1])
                else $error("ROM selected in lower half"); // R4
            AST_ROM_READ_ONLY: assert (rom_sel_n || wr_n)
                else $error("ROM selected on write"); // R5
            AST_ROM_TOP_BANK: assert (rom_sel_n || (win_size == SIZE_W'(MAX_CODE)) || rom_page == page_hi_bank)
                else $error("small window used lower bank page"); // R8
        end
    end

endmodule

// File: tb/tb_rom_window_mapper.sv
module tb_rom_window_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mreq_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] cpu_addr_hi = 8'h00;
    logic [2:0] win_size = 3'd0;
    logic [1:0] page_lo_bank = 2'd0;
    logic [1:0] page_hi_bank = 2'd0;
    logic       lo_ram_sel_n, hi_ram_sel_n, rom_sel_n;
    logic [1:0] rom_page;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rom_window_mapper dut (
        .mreq_n       (mreq_n),
        .wr_n         (wr_n),
        .cpu_addr_hi  (cpu_addr_hi),
        .win_size     (win_size),
        .page_lo_bank (page_lo_bank),
        .page_hi_bank (page_hi_bank),
        .lo_ram_sel_n (lo_ram_sel_n),
        .hi_ram_sel_n (hi_ram_sel_n),
        .rom_sel_n    (rom_sel_n),
        .rom_page     (rom_page)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h (addr_hi=%02h size=%0d mreq_n=%0b wr_n=%0b)",
                     tag, got, exp, cpu_addr_hi, win_size, mreq_n, wr_n);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=done");
            finish_run();
        end
    end

    initial begin
        int first_rom [8];
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state after reset
        check("R1 reset idle", {lo_ram_sel_n, hi_ram_sel_n, rom_sel_n}, 3'b111);

        for (int k = 0; k < 8; k++) first_rom[k] = 32'h10000;

        for (int s = 0; s < 8; s++) begin
            for (int a = 0; a < 256; a++) begin
                for (int m = 0; m < 4; m++) begin
                    int win_bytes, base, addr, exp_sel, idx;
                    bit in_win, req, wr;
                    string tag;
                    req = m[0];
                    wr  = m[1];
                    idx = s * 256 + a;
                    @(posedge clk);
                    win_size     = 3'(s);
                    cpu_addr_hi  = 8'(a);
                    mreq_n       = ~req;
                    wr_n         = ~wr;
                    page_lo_bank = 2'(idx % 4);
                    page_hi_bank = 2'((idx / 4 + 1) % 4);
                    @(negedge clk);
                    win_bytes = (s == 0) ? 0 : (256 << (s - 1));
                    base      = 32'h10000 - win_bytes;
                    addr      = a * 256;
                    in_win    = (s != 0) && (addr >= base);
                    // expected {lo, hi, rom}, active low
                    if (!req) begin
                        exp_sel = 3'b111; tag = "R1";
                    end else if (addr < 32'h8000) begin
                        exp_sel = 3'b011; tag = "R2";
                    end else if (!in_win) begin
                        exp_sel = 3'b101; tag = "R3";
                    end else if (!wr) begin
                        exp_sel = 3'b110; tag = "R5";
                    end else begin
                        exp_sel = 3'b101; tag = "R6";
                    end
                    check(tag, {lo_ram_sel_n, hi_ram_sel_n, rom_sel_n}, exp_sel);
                    // R9: select count
                    check("R9", $countones(~{lo_ram_sel_n, hi_ram_sel_n, rom_sel_n}), req ? 1 : 0);
                    // R7 / R8: page follows address bit 13
                    if (in_win && req && !wr && s < 7)
                        check("R8", rom_page, page_hi_bank);
                    else
                        check("R7", rom_page, ((addr >> 13) & 1) ? page_hi_bank : page_lo_bank);
                    if (req && !wr && !rom_sel_n && addr < first_rom[s])
                        first_rom[s] = addr;
                end
            end
        end

        // R4: lowest ROM-selecting address per size code
        for (int s = 0; s < 8; s++) begin
            int exp_base;
            exp_base = (s == 0) ? 32'h10000 : (32'h10000 - (256 << (s - 1)));
            check($sformatf("R4 base code %0d", s), first_rom[s], exp_base);
        end

        finish_run();
    end

endmodule